// File: doc/BRIEF.md
# Hoisted-Load Alias Monitor

This block watches for stores that hit the address of a load the compiler moved above them. When an advanced (hoisted) load executes, it records its destination register and the 8-byte-aligned granule of its address in a small associative table. Every store that follows compares its granule against all valid entries and clears each one that matches. The load then stays marked as possibly stale.

At the original program position, a check instruction names the destination register. If the register still has a valid entry, no store has touched the granule and the check has no effect. If the entry is missing, the check asks for the load to be reissued. The branching form of the check asks for a redirect to recovery code instead. A missing entry can mean the load was never recorded, was evicted, was killed by a store or was cleared by a flush.

The check result is registered and appears one cycle after the query. A flush input clears the whole table in one cycle. Addresses enter the block as granule indices, which are byte addresses shifted right by three.

Top module: `hoist_guard`

## Requirements
- R1: After reset the table holds no valid entry, `res_valid` is 0, and a check on any register returns a non-no-op result.
- R2: A check on a register that has a valid entry returns `res_action` = 2'b00 (no-op), whether or not `chk_branch` is set.
- R3: A store invalidates every valid entry whose granule equals the store granule, several entries in one cycle if they share it. A store to any other granule leaves every entry unchanged.
- R4: A check on a register with no valid entry returns 2'b01 (reload) when `chk_branch` is 0 and 2'b10 (redirect) when `chk_branch` is 1. The value 2'b11 is never produced.
- R5: `res_valid` is 1 exactly in the cycle after `chk_valid` was 1. The result reflects the table as it was before any store, allocation or flush in the same cycle as the check.
- R6: An allocation for a register that already has a valid entry overwrites that entry, so the register is then monitored only at its new granule.
- R7: An allocation for a register with no entry takes the lowest-numbered free entry. When no entry is free, it evicts the entry at a round-robin pointer. The pointer starts at entry 0 and advances by one after each eviction, wrapping at the last entry.
- R8: When a store and an allocation for the same granule occur in the same cycle, the store acts first, so the newly allocated entry remains valid.
- R9: A flush clears every valid bit in one cycle, drops any allocation in the same cycle, and resets the round-robin pointer to entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clear all table entries |
| alloc_valid | input | 1 | Advanced-load allocation request |
| alloc_reg | input | 7 | Destination register of the advanced load |
| alloc_gran | input | 29 | Address granule (byte address >> 3) of the advanced load |
| store_valid | input | 1 | Store snoop request |
| store_gran | input | 29 | Address granule of the store |
| chk_valid | input | 1 | Check query |
| chk_reg | input | 7 | Register being checked |
| chk_branch | input | 1 | 1 = branching check form |
| res_valid | output | 1 | Check result valid (one cycle after query) |
| res_action | output | 2 | 00 no-op, 01 reload, 10 redirect |

## Verification
Any corruption of a valid bit, register tag or granule tag shows up at the next check of the affected register. A wrongly killed entry turns a no-op into a reload or redirect, and a missed kill turns a needed reload into a no-op; both appear one cycle after the query. A wrong round-robin pointer or free-entry choice evicts the wrong register. This shows up only when the evicted register and its survivors are checked after the table fills, so the bench fills the table on purpose before it probes. A wrong ordering among store, allocation and flush in one cycle changes the result of the very next check.

// File: rtl/hg_pkg.sv
package hg_pkg;
  typedef enum logic [1:0] {
    ACT_NOP      = 2'b00,
    ACT_RELOAD   = 2'b01,
    ACT_REDIRECT = 2'b10
  } hg_action_e;
endpackage

// File: rtl/hg_match.sv
// Parallel compare of every entry against the store, allocate and check keys.
module hg_match #(
  parameter int ENTRIES = 16,
  parameter int REG_W   = 7,
  parameter int TAG_W   = 29
) (
  input  logic [ENTRIES-1:0]            vld,
  input  logic [ENTRIES-1:0][REG_W-1:0] ent_reg,
  input  logic [ENTRIES-1:0][TAG_W-1:0] ent_tag,
  input  logic [TAG_W-1:0]              store_tag,
  input  logic [REG_W-1:0]              alloc_reg,
  input  logic [REG_W-1:0]              chk_reg,
  output logic [ENTRIES-1:0]            store_hit,
  output logic [ENTRIES-1:0]            alloc_hit,
  output logic [ENTRIES-1:0]            chk_hit
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign store_hit[i] = vld[i] && (ent_tag[i] == store_tag);
    assign alloc_hit[i] = vld[i] && (ent_reg[i] == alloc_reg);
    assign chk_hit[i]   = vld[i] && (ent_reg[i] == chk_reg);
  end
endmodule

// File: rtl/hg_victim.sv
// Chooses the entry an allocation writes: same register, else free, else round-robin.
module hg_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] vld,
  input  logic [ENTRIES-1:0] alloc_hit,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic [IDX_W-1:0]   idx,
  output logic               evict
);
  logic             hit_found, free_found;
  logic [IDX_W-1:0] hit_idx, free_idx;

  always_comb begin
    hit_found  = 1'b0;
    free_found = 1'b0;
    hit_idx    = '0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (alloc_hit[i]) begin
        hit_found = 1'b1;
        hit_idx   = IDX_W'(i);
      end
      if (!vld[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
    if (hit_found) begin
      idx   = hit_idx;
      evict = 1'b0;
    end else if (free_found) begin
      idx   = free_idx;
      evict = 1'b0;
    end else begin
      idx   = rr_ptr;
      evict = 1'b1;
    end
  end
endmodule

// File: rtl/hoist_guard.sv
module hoist_guard
  import hg_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int REG_W   = 7,
  parameter int TAG_W   = 29,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             alloc_valid,
  input  logic [REG_W-1:0] alloc_reg,
  input  logic [TAG_W-1:0] alloc_gran,
  input  logic             store_valid,
  input  logic [TAG_W-1:0] store_gran,
  input  logic             chk_valid,
  input  logic [REG_W-1:0] chk_reg,
  input  logic             chk_branch,
  output logic             res_valid,
  output logic [1:0]       res_action
);
  logic [ENTRIES-1:0]            vld;
  logic [ENTRIES-1:0][REG_W-1:0] ent_reg;
  logic [ENTRIES-1:0][TAG_W-1:0] ent_tag;
  logic [IDX_W-1:0]              rr_ptr;
  logic [ENTRIES-1:0]            store_hit, alloc_hit, chk_hit;
  logic [IDX_W-1:0]              victim_idx;
  logic                          victim_evict;
  logic [ENTRIES-1:0]            kill_mask;
  hg_action_e                    act_q;

  hg_match #(.ENTRIES(ENTRIES), .REG_W(REG_W), .TAG_W(TAG_W)) u_match (
    .vld(vld), .ent_reg(ent_reg), .ent_tag(ent_tag),
    .store_tag(store_gran), .alloc_reg(alloc_reg), .chk_reg(chk_reg),
    .store_hit(store_hit), .alloc_hit(alloc_hit), .chk_hit(chk_hit)
  );

  hg_victim #(.ENTRIES(ENTRIES)) u_victim (
    .vld(vld), .alloc_hit(alloc_hit), .rr_ptr(rr_ptr),
    .idx(victim_idx), .evict(victim_evict)
  );

  assign kill_mask = store_valid ? store_hit : '0;

  // Valid bits, pointer and registered result.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld       <= '0;
      rr_ptr    <= '0;
      res_valid <= 1'b0;
      act_q     <= ACT_NOP;
    end else begin
      res_valid <= chk_valid;
      if (chk_valid)
        act_q <= (|chk_hit) ? ACT_NOP : (chk_branch ? ACT_REDIRECT : ACT_RELOAD);
      if (flush) begin
        vld    <= '0;
        rr_ptr <= '0;
      end else begin
        vld <= vld & ~kill_mask;
        if (alloc_valid) begin
          vld[victim_idx] <= 1'b1;  // after the store kill: allocation wins
          if (victim_evict)
            rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
        end
      end
    end
  end

  // Entry payload: no reset, single write port.
  always_ff @(posedge clk) begin
    if (alloc_valid && !flush && !rst) begin
      ent_reg[victim_idx] <= alloc_reg;
      ent_tag[victim_idx] <= alloc_gran;
    end
  end

  assign res_action = act_q;

  AST_RES_FOLLOWS_CHK: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> res_valid);  // R5
  AST_NO_SPURIOUS_RES: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !res_valid);  // R5
  AST_HIT_IS_NOP: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && (chk_hit != '0)) |=> (res_action == ACT_NOP));  // R2
  AST_BRANCH_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_branch) |=> (res_action != ACT_RELOAD));  // R4
  AST_STORE_KILLS: assert property (@(posedge clk) disable iff (rst)
    (store_valid && !alloc_valid && !flush) |=> ((vld & $past(store_hit)) == '0));  // R3
  AST_ALLOC_LANDS: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && !flush) |=> (vld[$past(victim_idx)] && ent_reg[$past(victim_idx)] == $past(alloc_reg)));  // R8
  AST_REG_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    alloc_valid |-> $onehot0(alloc_hit));  // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld == '0));  // R9
endmodule

// File: tb/hoist_guard_bench.sv
`timescale 1ns/1ps
module hoist_guard_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        flush, alloc_valid, store_valid, chk_valid, chk_branch;
  logic [6:0]  alloc_reg, chk_reg;
  logic [28:0] alloc_gran, store_gran;
  logic        res_valid;
  logic [1:0]  res_action;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  hoist_guard u_hoist_guard (
    .clk(clk), .rst(rst), .flush(flush),
    .alloc_valid(alloc_valid), .alloc_reg(alloc_reg), .alloc_gran(alloc_gran),
    .store_valid(store_valid), .store_gran(store_gran),
    .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_branch(chk_branch),
    .res_valid(res_valid), .res_action(res_action)
  );

  // {op[1:0] (1 alloc, 2 store, 3 check), branch, reg[6:0], granule[28:0], expected[1:0]}
  localparam int NV = 20;
  localparam logic [40:0] VEC [NV] = '{
    {2'd3, 1'b0, 7'd5, 29'h0,  2'd1},
    {2'd1, 1'b0, 7'd5, 29'h20, 2'd0},
    {2'd3, 1'b0, 7'd5, 29'h0,  2'd0},
    {2'd2, 1'b0, 7'd0, 29'h20, 2'd0},
    {2'd3, 1'b0, 7'd5, 29'h0,  2'd1},
    {2'd3, 1'b1, 7'd5, 29'h0,  2'd2},
    {2'd1, 1'b0, 7'd5, 29'h40, 2'd0},
    {2'd2, 1'b0, 7'd0, 29'h41, 2'd0},
    {2'd3, 1'b0, 7'd5, 29'h0,  2'd0},
    {2'd1, 1'b0, 7'd6, 29'h40, 2'd0},
    {2'd1, 1'b0, 7'd7, 29'h60, 2'd0},
    {2'd2, 1'b0, 7'd0, 29'h40, 2'd0},
    {2'd3, 1'b0, 7'd6, 29'h0,  2'd1},
    {2'd3, 1'b1, 7'd5, 29'h0,  2'd2},
    {2'd3, 1'b0, 7'd7, 29'h0,  2'd0},
    {2'd1, 1'b0, 7'd7, 29'h80, 2'd0},
    {2'd2, 1'b0, 7'd0, 29'h60, 2'd0},
    {2'd3, 1'b0, 7'd7, 29'h0,  2'd0},
    {2'd2, 1'b0, 7'd0, 29'h80, 2'd0},
    {2'd3, 1'b1, 7'd7, 29'h0,  2'd2}
  };

  task automatic idle();
    flush = 0; alloc_valid = 0; store_valid = 0; chk_valid = 0; chk_branch = 0;
    alloc_reg = '0; chk_reg = '0; alloc_gran = '0; store_gran = '0;
  endtask

  // Drive one cycle of stimulus at a falling edge; return at the next falling edge.
  task automatic step(input logic av, input logic [6:0] ar, input logic [28:0] ag,
                      input logic sv, input logic [28:0] sg,
                      input logic cv, input logic [6:0] cr, input logic cb,
                      input logic fl);
    alloc_valid = av; alloc_reg = ar; alloc_gran = ag;
    store_valid = sv; store_gran = sg;
    chk_valid = cv; chk_reg = cr; chk_branch = cb; flush = fl;
    @(negedge clk);
    idle();
  endtask

  task automatic expect_res(input logic [1:0] exp, input string tag);
    n_chk++;
    if (!res_valid || res_action !== exp) begin
      n_fail++;
      $display("FAIL %s: res_valid=%0b res_action=%0d expected valid=1 action=%0d",
               tag, res_valid, res_action, exp);
    end
  endtask

  task automatic do_alloc(input logic [6:0] r, input logic [28:0] g);
    step(1, r, g, 0, '0, 0, '0, 0, 0);
  endtask

  task automatic do_check(input logic [6:0] r, input logic b, input logic [1:0] exp,
                          input string tag);
    step(0, '0, '0, 0, '0, 1, r, b, 0);
    expect_res(exp, tag);
  endtask

  initial begin
    #(5.0 * 5000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    n_chk++;
    if (res_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: res_valid=%0b during reset, expected 0", res_valid);
    end
    rst = 0;
    @(negedge clk);
    do_check(7'd9, 1'b0, 2'd1, "R1");

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic        br;
      logic [6:0]  rg;
      logic [28:0] gr;
      logic [1:0]  ex;
      {op, br, rg, gr, ex} = VEC[i];
      case (op)
        2'd1: do_alloc(rg, gr);
        2'd2: step(0, '0, '0, 1, gr, 0, '0, 0, 0);
        default: do_check(rg, br, ex, (ex == 2'd0) ? "R2/R3/R6" : "R4/R3");
      endcase
    end

    // R5: non-check cycle gives no result
    step(0, '0, '0, 1, 29'h123, 0, '0, 0, 0);
    n_chk++;
    if (res_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R5: res_valid=%0b without check, expected 0", res_valid);
    end

    // R5: check sees the table before a same-cycle store
    do_alloc(7'd20, 29'h500);
    step(0, '0, '0, 1, 29'h500, 1, 7'd20, 0, 0);
    expect_res(2'd0, "R5");
    do_check(7'd20, 1'b0, 2'd1, "R5");

    // R8: store and allocation to the same granule together
    step(1, 7'd21, 29'h600, 1, 29'h600, 0, '0, 0, 0);
    do_check(7'd21, 1'b1, 2'd0, "R8");

    // R9: flush clears and drops the same-cycle allocation
    do_alloc(7'd22, 29'h700);
    step(1, 7'd23, 29'h800, 0, '0, 0, '0, 0, 1);
    do_check(7'd22, 1'b0, 2'd1, "R9");
    do_check(7'd23, 1'b1, 2'd2, "R9");

    // R7: fill all entries, then evict round-robin from entry 0
    for (int k = 0; k < 16; k++) do_alloc(7'(10 + k), 29'(16'h1000 + k));
    do_check(7'd25, 1'b0, 2'd0, "R7");
    do_alloc(7'd40, 29'h2000);
    do_check(7'd10, 1'b0, 2'd1, "R7");
    do_check(7'd40, 1'b0, 2'd0, "R7");
    do_check(7'd11, 1'b0, 2'd0, "R7");
    do_alloc(7'd41, 29'h2001);
    do_check(7'd11, 1'b1, 2'd2, "R7");
    do_check(7'd12, 1'b0, 2'd0, "R7");
    do_check(7'd41, 1'b0, 2'd0, "R7");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule